// File: doc/BRIEF.md
# Deferred-Fault Execution Pipeline

A fixed-latency execution pipeline whose operations carry a fault tag beside their result. Each stage has a fault input that stands in for an arithmetic exception detected while that stage works on its operation. A fault does not interrupt anything when it is detected. It is recorded in the operation's tag, and the tag travels down the pipe with the result. The fault is raised only at the exit, at the point where the result would be written to its destination register. Operations can therefore run speculatively. A squashed operation, or one whose result goes nowhere, never causes a trap.

The tag holds a cause code and the index of the stage that detected the fault. When the operation reaches writeback there are two outcomes. A clean operation writes its result to the register file. A faulting operation does not write; instead it pulses a trap strobe for one cycle and presents the cause, the stage and the destination index. Destinations below `SINK_COUNT` are sink registers, register 0 among them, and they neither write nor trap. A flush squashes every operation in flight. Each stage applies a placeholder transform to the data, chosen by a parameter; by default stage s adds s+1.

Top module: `trap_pipe`

## Requirements
- R1: `flt_req[s]` marks the operation that moves into stage s on that clock edge. Stage s takes its cause from `flt_cause[s*CAUSE_W +: CAUSE_W]`, and that stage samples `flt_req[s]` s cycles after the operation was issued.
- R2: Once an operation is marked, its mark stays set through every later stage up to writeback.
- R3: An operation issued on edge t appears at writeback on edge t+STAGES. If it is marked, `trap_stb` is 1 for that one cycle, and `trap_cause`, `trap_stage` and `trap_dst` hold the recorded cause, the detecting stage and the destination index.
- R4: An operation whose destination index is below `SINK_COUNT` (index 0 by default) never raises `trap_stb` and never raises `wb_en`.
- R5: When several stages mark the same operation, the cause and stage index of the lowest-numbered stage are kept.
- R6: `wb_en` and `trap_stb` are never 1 in the same cycle. A marked operation does not write.
- R7: An unmarked operation with a real destination raises `wb_en` for one cycle, STAGES edges after issue, with `wb_dst` equal to its destination and `wb_data` equal to the issued operand plus 1+2+...+STAGES (modulo 2^DATA_W) in the default transform.
- R8: A flush sampled on some edge removes the operation being issued on that edge and every operation already in flight. None of them writes or traps afterwards, and on the next cycle `wb_en` and `trap_stb` are 0.
- R9: During reset every output is 0.
- R10: When `wb_en` is 0, `wb_dst` and `wb_data` are 0. When `trap_stb` is 0, `trap_cause`, `trap_stage` and `trap_dst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Squash all in-flight operations and the one being issued |
| iss_vld | input | 1 | Issue a new operation this cycle |
| iss_data | input | DATA_W | Operand of the issued operation |
| iss_dst | input | IDX_W | Destination register index |
| flt_req | input | STAGES | Per-stage fault indication, bit s for stage s |
| flt_cause | input | STAGES*CAUSE_W | Per-stage fault cause, field s at bits s*CAUSE_W |
| wb_en | output | 1 | Register write strobe |
| wb_dst | output | IDX_W | Register written |
| wb_data | output | DATA_W | Value written |
| trap_stb | output | 1 | Trap raised at writeback |
| trap_cause | output | CAUSE_W | Cause recorded with the trap |
| trap_stage | output | $clog2(STAGES) | Stage that first detected the fault |
| trap_dst | output | IDX_W | Destination of the trapping operation |

## Verification
The checker watches every cycle for the properties that hold without knowing which operation is which. Writes and traps never occur together. Neither one ever targets a sink register. A reported stage index always lies inside the pipe. The cycle after a flush is quiet at writeback. The other behaviours depend on the history of a particular operation: the fixed latency, the data transform, which of several marks survives, and which operations a flush removes. Only the bench's reference model can show those. It plans each operation's faults when the operation is issued, follows it through the pipe and compares every output on every cycle.

// File: rtl/trap_pipe_pkg.sv
package trap_pipe_pkg;
   // Placeholder per-stage data transform
   typedef enum logic [0:0] {
      XF_ADD    = 1'b0,   // stage s adds s+1
      XF_ROTXOR = 1'b1    // stage s rotates left by one, then xors s+1
   } xform_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/trap_stage.sv
module trap_stage
   import trap_pipe_pkg::*;
#(
   parameter int     DATA_W   = 32,
   parameter int     IDX_W    = 5,
   parameter int     CAUSE_W  = 3,
   parameter int     SIDX_W   = 2,
   parameter int     STAGE_ID = 0,
   parameter xform_e XFORM    = XF_ADD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               in_vld,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [IDX_W-1:0]   in_dst,
   input  logic               in_trap,
   input  logic [CAUSE_W-1:0] in_cause,
   input  logic [SIDX_W-1:0]  in_sidx,
   input  logic               flt_req,
   input  logic [CAUSE_W-1:0] flt_cause,
   output logic               out_vld,
   output logic [DATA_W-1:0]  out_data,
   output logic [IDX_W-1:0]   out_dst,
   output logic               out_trap,
   output logic [CAUSE_W-1:0] out_cause,
   output logic [SIDX_W-1:0]  out_sidx
);
   localparam logic [DATA_W-1:0] K = DATA_W'(STAGE_ID + 1);

   logic [DATA_W-1:0]  nxt_data;
   logic               nxt_trap;
   logic [CAUSE_W-1:0] nxt_cause;
   logic [SIDX_W-1:0]  nxt_sidx;

   generate
      if (XFORM == XF_ADD) begin : g_add
         assign nxt_data = in_data + K;
      end else begin : g_rotxor
         assign nxt_data = {in_data[DATA_W-2:0], in_data[DATA_W-1]} ^ K;
      end
   endgenerate

   // An earlier mark wins; a new mark is taken only when none exists yet
   always_comb begin
      nxt_trap  = in_trap;
      nxt_cause = in_cause;
      nxt_sidx  = in_sidx;
      if (!in_trap && flt_req) begin
         nxt_trap  = 1'b1;
         nxt_cause = flt_cause;
         nxt_sidx  = SIDX_W'(STAGE_ID);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         out_vld   <= 1'b0;
         out_data  <= '0;
         out_dst   <= '0;
         out_trap  <= 1'b0;
         out_cause <= '0;
         out_sidx  <= '0;
      end else begin
         out_vld   <= in_vld;
         out_data  <= nxt_data;
         out_dst   <= in_dst;
         out_trap  <= in_vld & nxt_trap;
         out_cause <= in_vld ? nxt_cause : '0;
         out_sidx  <= in_vld ? nxt_sidx : '0;
      end
   end
endmodule

// File: rtl/trap_wb.sv
module trap_wb #(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 5,
   parameter int CAUSE_W    = 3,
   parameter int SIDX_W     = 2,
   parameter int SINK_COUNT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               in_vld,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [IDX_W-1:0]   in_dst,
   input  logic               in_trap,
   input  logic [CAUSE_W-1:0] in_cause,
   input  logic [SIDX_W-1:0]  in_sidx,
   output logic               wb_en,
   output logic [IDX_W-1:0]   wb_dst,
   output logic [DATA_W-1:0]  wb_data,
   output logic               trap_stb,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [SIDX_W-1:0]  trap_stage,
   output logic [IDX_W-1:0]   trap_dst
);
   logic is_sink, do_wr, do_trap;

   assign is_sink = (int'(in_dst) < SINK_COUNT);
   assign do_wr   = in_vld & ~in_trap & ~is_sink;
   assign do_trap = in_vld &  in_trap & ~is_sink;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wb_en      <= 1'b0;
         wb_dst     <= '0;
         wb_data    <= '0;
         trap_stb   <= 1'b0;
         trap_cause <= '0;
         trap_stage <= '0;
         trap_dst   <= '0;
      end else begin
         wb_en      <= do_wr;
         wb_dst     <= do_wr ? in_dst : '0;
         wb_data    <= do_wr ? in_data : '0;
         trap_stb   <= do_trap;
         trap_cause <= do_trap ? in_cause : '0;
         trap_stage <= do_trap ? in_sidx : '0;
         trap_dst   <= do_trap ? in_dst : '0;
      end
   end
endmodule

// File: rtl/trap_pipe.sv
module trap_pipe
   import trap_pipe_pkg::*;
#(
   parameter int     DATA_W     = 32,
   parameter int     IDX_W      = 5,
   parameter int     CAUSE_W    = 3,
   parameter int     STAGES     = 4,
   parameter int     SINK_COUNT = 1,
   parameter xform_e XFORM      = XF_ADD,
   localparam int    SIDX_W     = idx_width(STAGES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        iss_vld,
   input  logic [DATA_W-1:0]           iss_data,
   input  logic [IDX_W-1:0]            iss_dst,
   input  logic [STAGES-1:0]           flt_req,
   input  logic [STAGES*CAUSE_W-1:0]   flt_cause,
   output logic                        wb_en,
   output logic [IDX_W-1:0]            wb_dst,
   output logic [DATA_W-1:0]           wb_data,
   output logic                        trap_stb,
   output logic [CAUSE_W-1:0]          trap_cause,
   output logic [SIDX_W-1:0]           trap_stage,
   output logic [IDX_W-1:0]            trap_dst
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trap_pipe: STAGES must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("trap_pipe: DATA_W must be at least 2");
      end
      if (CAUSE_W < 1) begin : g_bad_cause
         $error("trap_pipe: CAUSE_W must be at least 1");
      end
      if (SINK_COUNT < 1 || SINK_COUNT >= (1 << IDX_W)) begin : g_bad_sink
         $error("trap_pipe: SINK_COUNT must lie in 1 .. 2**IDX_W-1");
      end
   endgenerate

   // Slot 0 is the issue port; slot s+1 is the register of stage s
   logic               v_q [STAGES+1];
   logic [DATA_W-1:0]  d_q [STAGES+1];
   logic [IDX_W-1:0]   r_q [STAGES+1];
   logic               t_q [STAGES+1];
   logic [CAUSE_W-1:0] c_q [STAGES+1];
   logic [SIDX_W-1:0]  s_q [STAGES+1];

   assign v_q[0] = iss_vld;
   assign d_q[0] = iss_data;
   assign r_q[0] = iss_dst;
   assign t_q[0] = 1'b0;
   assign c_q[0] = '0;
   assign s_q[0] = '0;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         trap_stage #(
            .DATA_W  (DATA_W),
            .IDX_W   (IDX_W),
            .CAUSE_W (CAUSE_W),
            .SIDX_W  (SIDX_W),
            .STAGE_ID(g),
            .XFORM   (XFORM)
         ) u_stg (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .in_vld   (v_q[g]),
            .in_data  (d_q[g]),
            .in_dst   (r_q[g]),
            .in_trap  (t_q[g]),
            .in_cause (c_q[g]),
            .in_sidx  (s_q[g]),
            .flt_req  (flt_req[g]),
            .flt_cause(flt_cause[g*CAUSE_W +: CAUSE_W]),
            .out_vld  (v_q[g+1]),
            .out_data (d_q[g+1]),
            .out_dst  (r_q[g+1]),
            .out_trap (t_q[g+1]),
            .out_cause(c_q[g+1]),
            .out_sidx (s_q[g+1])
         );
      end
   endgenerate

   trap_wb #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .CAUSE_W   (CAUSE_W),
      .SIDX_W    (SIDX_W),
      .SINK_COUNT(SINK_COUNT)
   ) u_wb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_vld    (v_q[STAGES]),
      .in_data   (d_q[STAGES]),
      .in_dst    (r_q[STAGES]),
      .in_trap   (t_q[STAGES]),
      .in_cause  (c_q[STAGES]),
      .in_sidx   (s_q[STAGES]),
      .wb_en     (wb_en),
      .wb_dst    (wb_dst),
      .wb_data   (wb_data),
      .trap_stb  (trap_stb),
      .trap_cause(trap_cause),
      .trap_stage(trap_stage),
      .trap_dst  (trap_dst)
   );
endmodule

// File: rtl/trap_pipe_chk.sv
module trap_pipe_chk #(
   parameter int IDX_W      = 5,
   parameter int STAGES     = 4,
   parameter int SINK_COUNT = 1,
   parameter int SIDX_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wb_en,
   input logic [IDX_W-1:0]  wb_dst,
   input logic              trap_stb,
   input logic [SIDX_W-1:0] trap_stage,
   input logic [IDX_W-1:0]  trap_dst
);
   AST_WRITE_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_en && trap_stb));                                            // R6
   AST_NO_SINK_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_stb |-> (int'(trap_dst) >= SINK_COUNT));                     // R4
   AST_NO_SINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (int'(wb_dst) >= SINK_COUNT));                          // R4
   AST_STAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_stb |-> (int'(trap_stage) < STAGES));                        // R5
   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!wb_en && !trap_stb));                                 // R8
endmodule

bind trap_pipe trap_pipe_chk #(
   .IDX_W     (IDX_W),
   .STAGES    (STAGES),
   .SINK_COUNT(SINK_COUNT),
   .SIDX_W    (SIDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .wb_en     (wb_en),
   .wb_dst    (wb_dst),
   .trap_stb  (trap_stb),
   .trap_stage(trap_stage),
   .trap_dst  (trap_dst)
);

// File: tb/sim_trap_pipe.sv
`timescale 1ns/1ps
module sim_trap_pipe;
   localparam int S  = 4;
   localparam int DW = 32;
   localparam int IW = 5;
   localparam int CW = 3;
   localparam int SW = 2;
   localparam int NC = 300;
   localparam int NA = NC + S + 4;
   localparam int OW = 1 + IW + DW + 1 + CW + SW + IW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              iss_vld = 1'b0;
   logic [DW-1:0]     iss_data = '0;
   logic [IW-1:0]     iss_dst = '0;
   logic [S-1:0]      flt_req = '0;
   logic [S*CW-1:0]   flt_cause = '0;
   logic              wb_en, trap_stb;
   logic [IW-1:0]     wb_dst, trap_dst;
   logic [DW-1:0]     wb_data;
   logic [CW-1:0]     trap_cause;
   logic [SW-1:0]     trap_stage;

   always #2 clk = ~clk;   // 250 MHz

   trap_pipe #(.DATA_W(DW), .IDX_W(IW), .CAUSE_W(CW), .STAGES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .iss_vld(iss_vld),
      .iss_data(iss_data), .iss_dst(iss_dst), .flt_req(flt_req),
      .flt_cause(flt_cause), .wb_en(wb_en), .wb_dst(wb_dst),
      .wb_data(wb_data), .trap_stb(trap_stb), .trap_cause(trap_cause),
      .trap_stage(trap_stage), .trap_dst(trap_dst));

   // Plan of every operation, indexed by its issue cycle
   logic            p_vld   [NA];
   logic [DW-1:0]   p_data  [NA];
   logic [IW-1:0]   p_dst   [NA];
   logic [S-1:0]    p_fmask [NA];
   logic [S*CW-1:0] p_cause [NA];
   logic            p_flush [NA];
   logic            p_kill  [NA];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   function automatic logic [OW-1:0] expect_at(int idx);
      logic [DW-1:0] d;
      if (idx < 0 || !p_vld[idx] || p_kill[idx]) return '0;
      if (p_dst[idx] == 0) return '0;                        // R4
      d = p_data[idx];
      for (int s = 0; s < S; s++) d = d + DW'(s + 1);         // R7
      for (int s = 0; s < S; s++)
         if (p_fmask[idx][s])                                  // R5 earliest
            return {1'b0, IW'(0), DW'(0), 1'b1,
                    p_cause[idx][s*CW +: CW], SW'(s), p_dst[idx]};
      return {1'b1, p_dst[idx], d, 1'b0, CW'(0), SW'(0), IW'(0)};
   endfunction

   function automatic string tag_of(int idx);
      if (idx < 0 || !p_vld[idx]) return "R10";
      if (p_kill[idx]) return "R8";
      if (p_dst[idx] == 0) return "R4";
      if (p_fmask[idx] != 0) return "R1/R2/R3/R5/R6";
      return "R7";
   endfunction

   task automatic check(string tag, logic [OW-1:0] exp);
      logic [OW-1:0] act;
      act = {wb_en, wb_dst, wb_data, trap_stb, trap_cause, trap_stage, trap_dst};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic plan(int c, logic [DW-1:0] d, logic [IW-1:0] r,
                       logic [S-1:0] m, logic [S*CW-1:0] cs);
      p_vld[c] = 1'b1; p_data[c] = d; p_dst[c] = r;
      p_fmask[c] = m;  p_cause[c] = cs;
   endtask

   initial begin
      for (int i = 0; i < NA; i++) begin
         p_vld[i] = 0; p_data[i] = '0; p_dst[i] = '0; p_fmask[i] = '0;
         p_cause[i] = '0; p_flush[i] = 0; p_kill[i] = 0;
      end
      // Directed cases; cause field s sits at bits s*CW
      plan(0, 32'd100, 5'd5, 4'b0000, '0);                      // R7 clean
      plan(1, 32'd7,   5'd7, 4'b0100, 12'(5 << (2*CW)));        // R1 R2 R3 stage 2
      plan(2, 32'd9,   5'd3, 4'b1010, 12'((6 << (3*CW)) | (2 << CW))); // R5
      plan(3, 32'd1,   5'd0, 4'b0001, 12'd4);                   // R4 sink, fault
      plan(4, 32'd2,   5'd0, 4'b0000, '0);                      // R4 sink, clean
      plan(5, 32'hFFFF_FFFF, 5'd9, 4'b0001, 12'd1);             // R6 stage 0
      for (int i = 6; i < 10; i++) plan(i, 32'(i * 1000), 5'(i + 10), '0, '0);
      plan(12, 32'd55, 5'd12, 4'b1000, 12'(3 << (3*CW)));       // R8 squashed
      plan(13, 32'd66, 5'd13, 4'b0000, '0);                     // R8 squashed
      p_flush[14] = 1'b1;
      plan(15, 32'd77, 5'd15, 4'b0000, '0);                     // after flush
      for (int i = 20; i < NC; i++) begin
         if ($urandom_range(0, 3) != 0)
            plan(i, $urandom, ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom),
                 ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0000,
                 12'($urandom));
         p_flush[i] = ($urandom_range(0, 40) == 0);
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9", '0);                                          // R9 reset
      rst_n = 1'b1;
      for (int n = 0; n < NA; n++) begin
         @(negedge clk);
         if (n > 0) check(tag_of(n - 1 - S), expect_at(n - 1 - S));
         flush = p_flush[n];
         if (p_flush[n])
            for (int k = n - S; k <= n; k++) if (k >= 0) p_kill[k] = 1'b1;
         iss_vld  = p_vld[n];
         iss_data = p_data[n];
         iss_dst  = p_dst[n];
         for (int s = 0; s < S; s++) begin
            flt_req[s] = (n - s >= 0) ? p_fmask[n-s][s] : 1'b0;
            flt_cause[s*CW +: CW] = (n - s >= 0) ? p_cause[n-s][s*CW +: CW] : '0;
         end
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule